// File: doc/BRIEF.md
# Iterative Nonrestoring Fractional Divider

This unit divides a signed accumulator value by a signed fractional divisor. It forms one quotient bit per clock with the nonrestoring method. The caller pulses `start_i` together with the accumulator operand, the divisor and a step count. The unit then runs that many steps with no further input and pulses `done_o`.

A single register holds the whole accumulator. Its upper field (the extension bits plus the upper divisor-width field) carries the signed partial remainder. Its low divisor-width field collects the quotient bits as they are shifted in. Each step does the following, in order:
- It looks at the accumulator sign bit and the divisor sign bit.
- It shifts the accumulator left by one, inserting the current quotient flag at bit 0.
- It adds the divisor to the upper field when the two sign bits differ, and subtracts it otherwise.
- It sets the quotient flag to the complement of the XOR of the new accumulator sign and the divisor sign.

The last quotient bit is left in the flag, so a full result is the low field shifted left by one with the flag appended. The unit does not correct the quotient sign or the remainder. It reports the need for a quotient negation on `qneg_o`, and reports operands outside the valid range on `invalid_o`.

Top module: `nrdiv_iter`

## Requirements
- R1: After reset, `acc_o`, `quo_bit_o`, `done_o`, `qneg_o` and `invalid_o` are all 0.
- R2: The operation runs in steps, and every step is computed the same way.
  - Let `ACC_W = EXT_W + 2*DIV_W`. A start loads the operand and clears the quotient flag.
  - A step first computes `s = acc[ACC_W-1] ^ div[DIV_W-1]`.
  - It then shifts the accumulator left by one, with the flag entering bit 0.
  - It then adds the sign-extended divisor to bits `ACC_W-1..DIV_W` if `s` is 1, and subtracts it if `s` is 0. Arithmetic is modulo 2^(EXT_W+DIV_W). Bits `DIV_W-1..0` are not touched by the add or subtract.
  - Finally, the flag becomes `~(acc[ACC_W-1] ^ div[DIV_W-1])`, using the new accumulator value.
- R3: `done_o` is high for exactly one cycle. It is first seen high N clock edges after the edge that accepted the start, where N is the effective step count.
- R4: Take a dividend A with 0 <= A, a divisor S > 0, A < S*2^DIV_W, and N = DIV_W. Then `{acc_o[DIV_W-2:0], quo_bit_o}` equals floor(A/S).
- R5: On every step, the low field shifts up by one, and the previous quotient flag appears at bit 0.
- R6: A step count of 0 runs 1 step. A step count above `DIV_W` runs `DIV_W` steps.
- R7: `qneg_o` equals `acc_i[ACC_W-1] ^ div_i[DIV_W-1]`, sampled when the start is accepted.
- R8: `invalid_o` is 1 exactly when |acc_i| >= |div_i|*2^DIV_W, with both operands read as two's complement, sampled at start. This includes every zero divisor. The division still runs.
- R9: A start pulse while a division is running is ignored. The result equals that of the undisturbed division.
- R10: When idle with no start, all outputs except `done_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| acc_i | input | ACC_W | Initial accumulator (sign-extended dividend) |
| div_i | input | DIV_W | Signed fractional divisor |
| steps_i | input | CNT_W | Requested step count |
| acc_o | output | ACC_W | Accumulator: remainder high, formed quotient low |
| quo_bit_o | output | 1 | Quotient flag, the next quotient bit |
| done_o | output | 1 | One-cycle completion pulse |
| qneg_o | output | 1 | Formed quotient needs negation |
| invalid_o | output | 1 | Operand magnitudes outside the valid range |

## Verification
The bench builds the unit with `EXT_W = 2` and `DIV_W = 6`, which gives a 14-bit accumulator and a 3-bit step count. With that size, every one of the 64 divisor codes, including zero and the most negative, is paired with dividends spread over the whole signed range. Every step count from 0 to 7 is reached, including the two out-of-range codes that must be clamped.

For positive operands run at the full count, the quotient is checked against plain integer division. The start-while-busy and hold-when-idle cases are also driven.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } step_op_e;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int EXT_W = 8,
    parameter int DIV_W = 24,
    localparam int ACC_W = EXT_W + 2 * DIV_W
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [DIV_W-1:0] dvs_i,
    input  logic             cbit_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             cbit_o
);
    localparam int HI_W = EXT_W + DIV_W;

    nrdiv_pkg::step_op_e op;
    logic [ACC_W-1:0]    shifted;
    logic [HI_W-1:0]     dvs_ext;
    logic [HI_W-1:0]     hi_new;

    always_comb begin
        op      = (acc_i[ACC_W-1] ^ dvs_i[DIV_W-1]) ? nrdiv_pkg::OP_ADD : nrdiv_pkg::OP_SUB;
        shifted = {acc_i[ACC_W-2:0], cbit_i};
        dvs_ext = {{EXT_W{dvs_i[DIV_W-1]}}, dvs_i};
        if (op == nrdiv_pkg::OP_ADD) begin
            hi_new = shifted[ACC_W-1:DIV_W] + dvs_ext;
        end else begin
            hi_new = shifted[ACC_W-1:DIV_W] - dvs_ext;
        end
        acc_o  = {hi_new, shifted[DIV_W-1:0]};
        cbit_o = ~(hi_new[HI_W-1] ^ dvs_i[DIV_W-1]);
    end
endmodule

// File: rtl/nrdiv_range.sv
module nrdiv_range #(
    parameter int EXT_W = 8,
    parameter int DIV_W = 24,
    localparam int ACC_W = EXT_W + 2 * DIV_W
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [DIV_W-1:0] dvs_i,
    output logic             ok_o
);
    logic [ACC_W:0] a_ext, a_mag;
    logic [ACC_W:0] d_ext, d_mag;

    always_comb begin
        a_ext = {acc_i[ACC_W-1], acc_i};
        a_mag = a_ext[ACC_W] ? (~a_ext + 1'b1) : a_ext;
        d_ext = {{(EXT_W + 1){dvs_i[DIV_W-1]}}, dvs_i, {DIV_W{1'b0}}};
        d_mag = d_ext[ACC_W] ? (~d_ext + 1'b1) : d_ext;
        ok_o  = (a_mag < d_mag);
    end
endmodule

// File: rtl/nrdiv_iter.sv
module nrdiv_iter #(
    parameter int EXT_W = 8,
    parameter int DIV_W = 24,
    localparam int ACC_W = EXT_W + 2 * DIV_W,
    localparam int CNT_W = $clog2(DIV_W + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [CNT_W-1:0] steps_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             quo_bit_o,
    output logic             done_o,
    output logic             qneg_o,
    output logic             invalid_o
);
    localparam logic [CNT_W-1:0] MAX_STEPS = CNT_W'(DIV_W);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [DIV_W-1:0] dvs;
        logic             cbit;
        logic [CNT_W-1:0] left;
        logic             run;
        logic             done;
        logic             qneg;
        logic             bad;
    } state_t;

    state_t st_d, st_q;

    logic [ACC_W-1:0] step_acc_d;
    logic             step_cbit_d;
    logic             range_ok_d;
    logic [CNT_W-1:0] steps_clamped_d;

    nrdiv_step #(.EXT_W(EXT_W), .DIV_W(DIV_W)) u_step (
        .acc_i  (st_q.acc),
        .dvs_i  (st_q.dvs),
        .cbit_i (st_q.cbit),
        .acc_o  (step_acc_d),
        .cbit_o (step_cbit_d)
    );

    nrdiv_range #(.EXT_W(EXT_W), .DIV_W(DIV_W)) u_range (
        .acc_i (acc_i),
        .dvs_i (div_i),
        .ok_o  (range_ok_d)
    );

    always_comb begin
        if (steps_i == '0) begin
            steps_clamped_d = CNT_W'(1);
        end else if (steps_i > MAX_STEPS) begin
            steps_clamped_d = MAX_STEPS;
        end else begin
            steps_clamped_d = steps_i;
        end

        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.run) begin
            st_d.acc  = step_acc_d;
            st_d.cbit = step_cbit_d;
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == CNT_W'(1)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i) begin
            st_d.acc  = acc_i;
            st_d.dvs  = div_i;
            st_d.cbit = 1'b0;
            st_d.left = steps_clamped_d;
            st_d.run  = 1'b1;
            st_d.qneg = acc_i[ACC_W-1] ^ div_i[DIV_W-1];
            st_d.bad  = ~range_ok_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o     = st_q.acc;
    assign quo_bit_o = st_q.cbit;
    assign done_o    = st_q.done;
    assign qneg_o    = st_q.qneg;
    assign invalid_o = st_q.bad;
endmodule

// File: rtl/nrdiv_iter_chk.sv
module nrdiv_iter_chk #(
    parameter int EXT_W = 8,
    parameter int DIV_W = 24,
    localparam int ACC_W = EXT_W + 2 * DIV_W,
    localparam int CNT_W = $clog2(DIV_W + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             quo_bit_o,
    input logic             done_o,
    input logic             qneg_o,
    input logic             invalid_o,
    input logic             run,
    input logic [DIV_W-1:0] dvs,
    input logic [CNT_W-1:0] left
);
    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R3: the last step ends the run and raises done
    a_r3_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && left == CNT_W'(1)) |=> (done_o && !run));

    // R5: quotient field shifts and takes in the previous flag
    a_r5_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |=> (acc_o[DIV_W-1:1] == $past(acc_o[DIV_W-2:0]) && acc_o[0] == $past(quo_bit_o)));

    // R2: flag after a step agrees with the new sign and the divisor sign
    a_r2_flag_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(run) |-> (quo_bit_o == ~(acc_o[ACC_W-1] ^ dvs[DIV_W-1])));

    // R9: start while busy leaves the captured operation unchanged
    a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && start_i) |=> ($stable(qneg_o) && $stable(dvs) && $stable(invalid_o)));

    // R10: idle without start holds the outputs
    a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !start_i) |=> ($stable(acc_o) && $stable(quo_bit_o) && $stable(qneg_o)));
endmodule

bind nrdiv_iter nrdiv_iter_chk #(.EXT_W(EXT_W), .DIV_W(DIV_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .acc_o     (acc_o),
    .quo_bit_o (quo_bit_o),
    .done_o    (done_o),
    .qneg_o    (qneg_o),
    .invalid_o (invalid_o),
    .run       (st_q.run),
    .dvs       (st_q.dvs),
    .left      (st_q.left)
);

// File: tb/sim_nrdiv_iter.sv
module sim_nrdiv_iter;
    localparam int EXT_W = 2;
    localparam int DIV_W = 6;
    localparam int ACC_W = EXT_W + 2 * DIV_W;
    localparam int CNT_W = $clog2(DIV_W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [ACC_W-1:0] acc_in = '0;
    logic [DIV_W-1:0] div_in = '0;
    logic [CNT_W-1:0] steps_in = '0;
    logic [ACC_W-1:0] acc_out;
    logic             qbit, done, qneg, invalid;

    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nrdiv_iter #(.EXT_W(EXT_W), .DIV_W(DIV_W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_i(acc_in),
        .div_i(div_in), .steps_i(steps_in), .acc_o(acc_out), .quo_bit_o(qbit),
        .done_o(done), .qneg_o(qneg), .invalid_o(invalid)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result from the R2 step rule, as {flag, accumulator}
    function automatic logic [ACC_W:0] model(input int a, input int s, input int n);
        logic [ACC_W-1:0] r;
        logic [ACC_W-1:0] sh;
        logic [DIV_W-1:0] sv;
        logic             c, add;
        r  = ACC_W'(a);
        sv = DIV_W'(s);
        c  = 1'b0;
        sh = {{EXT_W{sv[DIV_W-1]}}, sv, {DIV_W{1'b0}}};
        for (int i = 0; i < n; i++) begin
            add = r[ACC_W-1] ^ sv[DIV_W-1];
            r   = {r[ACC_W-2:0], c};
            r   = add ? r + sh : r - sh;
            c   = ~(r[ACC_W-1] ^ sv[DIV_W-1]);
        end
        return {c, r};
    endfunction

    function automatic int eff_steps(input int n);
        if (n == 0) return 1;
        if (n > DIV_W) return DIV_W;
        return n;
    endfunction

    // a: signed dividend, s: signed divisor, n: step code, poke: start while busy
    task automatic run_one(input int a, input int s, input int n, input bit poke, input string tag);
        int               lat;
        int               en;
        int               sv;
        int               ma, ms;
        logic [ACC_W:0]   exp;
        logic [DIV_W-1:0] s_bits;
        @(negedge clk);
        start    = 1'b1;
        acc_in   = ACC_W'(a);
        div_in   = DIV_W'(s);
        steps_in = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start    = 1'b1;
            acc_in   = ACC_W'(a ^ 1234);
            div_in   = ~DIV_W'(s);
            steps_in = CNT_W'(1);
        end
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        en     = eff_steps(n);
        exp    = model(a, s, en);
        s_bits = DIV_W'(s);
        sv     = int'($signed(s_bits));
        ma     = (a < 0) ? -a : a;
        ms     = ((sv < 0) ? -sv : sv) * (1 << DIV_W);
        check({tag, " R3 latency"}, lat, en);
        check({tag, " R2 accumulator"}, acc_out, exp[ACC_W-1:0]);
        check({tag, " R2 flag"}, qbit, exp[ACC_W]);
        check({tag, " R7 qneg"}, qneg, ((a < 0) ? 1 : 0) ^ ((sv < 0) ? 1 : 0));
        check({tag, " R8 invalid"}, invalid, (ma >= ms) ? 1 : 0);
        if (a >= 0 && sv > 0 && ma < ms && en == DIV_W) begin
            check({tag, " R4 quotient"}, {acc_out[DIV_W-2:0], qbit}, a / sv);
        end
        @(negedge clk);
        check({tag, " R3 done single"}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 acc", acc_out, 0);
        check("R1 flag", qbit, 0);
        check("R1 done", done, 0);
        check("R1 qneg", qneg, 0);
        check("R1 invalid", invalid, 0);
        rst_n = 1'b1;

        // Sweep: every divisor code against dividends over the signed range
        for (int s = 0; s < (1 << DIV_W); s++) begin
            for (int a = -(1 << (ACC_W - 1)); a < (1 << (ACC_W - 1)); a += 331) begin
                run_one(a, s, DIV_W, 1'b0, "sweep");
            end
            for (int a = 0; a < (1 << (2 * DIV_W - 1)); a += 97) begin
                run_one(a, s, DIV_W, 1'b0, "pos");
            end
        end

        // R6: every step code including out-of-range ones
        for (int n = 0; n < (1 << CNT_W); n++) begin
            run_one(700, 13, n, 1'b0, "R6 steps");
            run_one(1500, -27, n, 1'b0, "R6 steps neg");
        end

        // R9: start while busy
        run_one(900, 19, DIV_W, 1'b1, "R9 busy start");
        run_one(-600, 25, 3, 1'b1, "R9 busy start short");

        // R10: outputs hold while idle
        run_one(1111, 22, DIV_W, 1'b0, "R10 setup");
        begin
            logic [ACC_W-1:0] keep_acc;
            logic             keep_q;
            keep_acc = acc_out;
            keep_q   = qbit;
            repeat (5) @(negedge clk);
            check("R10 acc hold", acc_out, keep_acc);
            check("R10 flag hold", qbit, keep_q);
            check("R10 done low", done, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule